// File: doc/BRIEF.md
# Programmable Interrupt Controller Configuration Unit

This block is the register-programming front end of an eight-input priority interrupt controller. The controller can work alone or as one member of a master/slave chain. Software reaches it through two byte-wide ports that share one write bus, selected by `port_sel`:

- **Command port** (`port_sel` = 0) starts the initialization sequence and takes end-of-interrupt commands.
- **Data port** (`port_sel` = 1) takes the initialization words that follow the command and, after that, the input mask.

The first initialization word decides which of the later words are expected. The block keeps the resulting configuration: vector base, cascade word, trigger style and end-of-interrupt style. It arbitrates among pending, unmasked inputs with fixed priority and raises an interrupt request together with the vector of the winning input. When the request is acknowledged, the block moves that input into service unless automatic end-of-interrupt is set. A non-specific end-of-interrupt command retires the highest-priority input in service.

The cascade word has two meanings. On a master (`master_sel` = 1) it is a bitmask of the inputs that have a slave attached. On a slave it is the slave's own three-bit identity.

Top module: `pic_cfg_unit`

## Requirements
- R1: While reset is held and right after it, `cfg_ready` is 0, `int_req` is 0 and a data-port read returns 0xFF. Reset masks every input.
- R2: A command-port write with bit 4 set starts initialization. In the following cycle the mask, in-service and request state are all zero, `cfg_ready` is 0, and the next data-port write is taken as the vector base.
- R3: In the start word, bit 1 = 1 means single controller, so no cascade word is taken. Bit 0 = 1 means a mode word follows. The data-port write that supplies the last expected word makes `cfg_ready` 1 in the next cycle.
- R4: While `int_req` is 1, `int_vector` equals the vector base plus the index of the requesting input, modulo 256.
- R5: On a master, `cfg_slave_mask` shows the cascade word and `cfg_slave_id` is 0. On a slave, `cfg_slave_id` shows bits 2:0 of the cascade word and `cfg_slave_mask` is 0. Both read 0 after a sequence that skips the cascade word.
- R6: Bit 1 of the mode word selects automatic end-of-interrupt (shown on `cfg_auto_eoi`). In that mode an acknowledge puts nothing in service, so the next pending input may request at once.
- R7: Once ready, each data-port write loads the mask. A read (`rd_en`=1, `port_sel`=1) returns it, and any other read returns 0. A set bit blocks its input, so 0xFF blocks all eight.
- R8: Priority is fixed, with input 0 highest. `int_req` is 1 only when ready and when some unmasked pending input outranks every input in service.
- R9: An acknowledge while `int_req` is 1 clears the winner's pending request and, with normal end-of-interrupt, puts it in service, which blocks it and every lower-priority input.
- R10: A command-port write once ready with bits 7:5 = 001 and bits 4:3 = 00 (for example 0x20) is a non-specific end-of-interrupt. It takes the highest-priority input out of service.
- R11: Bit 3 of the start word selects level mode (shown on `cfg_level_mode`). In edge mode a request is latched only on a rising input, and an input held high after service does not request again. In level mode the request follows the input one cycle later.
- R12: Data-port writes before the first initialization leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe for the selected port |
| port_sel | input | 1 | 0 selects the command port, 1 selects the data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: the mask on a data-port read, otherwise 0 |
| master_sel | input | 1 | 1 makes this controller a master, 0 a slave |
| irq_in | input | 8 | Interrupt inputs, index 0 highest priority |
| int_ack | input | 1 | Acknowledge of the current request |
| int_req | output | 1 | Interrupt request |
| int_vector | output | 8 | Vector of the requesting input; 0 when no request |
| cfg_ready | output | 1 | Initialization sequence complete |
| cfg_level_mode | output | 1 | 1 for level-triggered inputs |
| cfg_auto_eoi | output | 1 | 1 for automatic end-of-interrupt |
| cfg_slave_mask | output | 8 | Cascade bitmask (master only) |
| cfg_slave_id | output | 3 | Cascade identity (slave only) |

## Verification
The bench targets these corner cases, and each has a visible failure signature:

- **Word sequencing.** It runs start words that skip the cascade word, skip the mode word, or keep both. A sequencer that counts words wrongly would store the base or the cascade word in the wrong field, or would raise ready one write early or late.
- **Nesting under service.** It lets a lower-priority input arrive while a higher one is in service, and a higher one arrive while a lower one is in service. A wrong in-service comparison would either let the lower input interrupt the handler or hold off the higher one.
- **End-of-interrupt retirement.** Successive end-of-interrupt commands must retire inputs from the top of the in-service set, exposing the lower pending input only at the last one. An end-of-interrupt that cleared the wrong bit would release the lower input too early.
- **Trigger and acknowledge modes.** Edge mode must not re-request for an input held high after service, where a level-following latch would re-request. Level mode must drop the request when the input falls. In automatic end-of-interrupt mode the next input must follow straight after an acknowledge.

// File: rtl/pic_cfg_pkg.sv
package pic_cfg_pkg;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_WBASE  = 3'd1,
    ST_WCASC  = 3'd2,
    ST_WMODE  = 3'd3,
    ST_READY  = 3'd4
  } init_st_e;

  // start-word and command-word bit positions
  localparam int unsigned START_BIT  = 4;
  localparam int unsigned MODE_FOLLOWS_BIT = 0;
  localparam int unsigned SINGLE_BIT = 1;
  localparam int unsigned LEVEL_BIT  = 3;
  localparam int unsigned AEOI_BIT   = 1;

endpackage

// File: rtl/pic_rst_sync.sv
module pic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_ns = stage2_q;

endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_cfg_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          wr_en,
  input  logic          port_sel,
  input  logic [DW-1:0] wdata,
  output logic          cmd_init,
  output logic          cmd_eoi,
  output logic          ready,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_word,
  output logic          level_mode,
  output logic          auto_eoi,
  output logic [DW-1:0] mask
);

  init_st_e      st_q, st_nx;
  logic          need_mode_q;
  logic          single_q;
  logic          level_q;
  logic          aeoi_q;
  logic [DW-1:0] base_q;
  logic [DW-1:0] casc_q;
  logic [DW-1:0] mask_q;

  logic cmd_wr;
  logic dat_wr;
  logic ld_base;
  logic ld_casc;
  logic ld_mode;
  logic ld_mask;

  // port decode
  always_comb begin
    cmd_wr   = wr_en & ~port_sel;
    dat_wr   = wr_en & port_sel;
    cmd_init = cmd_wr & wdata[START_BIT];
    cmd_eoi  = cmd_wr & ~wdata[START_BIT] & ~wdata[3] &
               (wdata[7:5] == 3'b001) & (st_q == ST_READY);
    ld_base  = dat_wr & (st_q == ST_WBASE);
    ld_casc  = dat_wr & (st_q == ST_WCASC);
    ld_mode  = dat_wr & (st_q == ST_WMODE);
    ld_mask  = dat_wr & (st_q == ST_READY);
  end

  // next state
  always_comb begin
    st_nx = st_q;
    if (cmd_init) begin
      st_nx = ST_WBASE;
    end else if (dat_wr) begin
      case (st_q)
        ST_WBASE: begin
          if (!single_q)        st_nx = ST_WCASC;
          else if (need_mode_q) st_nx = ST_WMODE;
          else                  st_nx = ST_READY;
        end
        ST_WCASC: st_nx = need_mode_q ? ST_WMODE : ST_READY;
        ST_WMODE: st_nx = ST_READY;
        default:  st_nx = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= ST_UNINIT;
    end else begin
      st_q <= st_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      need_mode_q <= 1'b0;
      single_q    <= 1'b0;
      level_q     <= 1'b0;
    end else if (cmd_init) begin
      need_mode_q <= wdata[MODE_FOLLOWS_BIT];
      single_q    <= wdata[SINGLE_BIT];
      level_q     <= wdata[LEVEL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      base_q <= '0;
    end else if (ld_base) begin
      base_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      casc_q <= '0;
    end else if (cmd_init) begin
      casc_q <= '0;
    end else if (ld_casc) begin
      casc_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      aeoi_q <= 1'b0;
    end else if (cmd_init) begin
      aeoi_q <= 1'b0;
    end else if (ld_mode) begin
      aeoi_q <= wdata[AEOI_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mask_q <= '1;
    end else if (cmd_init) begin
      mask_q <= '0;
    end else if (ld_mask) begin
      mask_q <= wdata;
    end
  end

  assign ready      = (st_q == ST_READY);
  assign vec_base   = base_q;
  assign casc_word  = casc_q;
  assign level_mode = level_q;
  assign auto_eoi   = aeoi_q;
  assign mask       = mask_q;

  // R2
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_init |=> (st_q == ST_WBASE) && (mask_q == '0));

  // R3
  skip_all_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ld_base && single_q && !need_mode_q |=> st_q == ST_READY);

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ld_mask |=> mask_q == $past(wdata));

  // R12
  early_write_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    dat_wr && (st_q == ST_UNINIT) |=> $stable(mask_q));

endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_ns,
  input  logic [N-1:0] irq,
  input  logic         level_mode,
  input  logic         clr_all,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);

  logic [N-1:0] prev_q;
  logic [N-1:0] irr_q;
  logic [N-1:0] irr_nx;

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_line
      always_comb begin
        if (clr_all)         irr_nx[gi] = 1'b0;
        else if (level_mode) irr_nx[gi] = irq[gi];
        else                 irr_nx[gi] = (irr_q[gi] & ~ack_clr[gi]) |
                                          (irq[gi] & ~prev_q[gi]);
      end

      // R11
      edge_only_chk: assert property (@(posedge clk) disable iff (!rst_ns)
        !level_mode && !clr_all && !irr_q[gi] && !(irq[gi] && !prev_q[gi])
        |=> !irr_q[gi]);

      // R11
      level_follow_chk: assert property (@(posedge clk) disable iff (!rst_ns)
        level_mode && !clr_all |=> irr_q[gi] == $past(irq[gi]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq;
      irr_q  <= irr_nx;
    end
  end

  assign irr = irr_q;

endmodule

// File: rtl/pic_prio_svc.sv
module pic_prio_svc #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  mask,
  input  logic          ready,
  input  logic          ack,
  input  logic          eoi,
  input  logic          clr_all,
  input  logic          auto_eoi,
  output logic          int_req,
  output logic [IW-1:0] grant_idx,
  output logic [N-1:0]  ack_clr
);

  logic [N-1:0]  isr_q;
  logic [N-1:0]  isr_nx;
  logic [N-1:0]  cand;
  logic          cand_any;
  logic [IW-1:0] cand_idx;
  logic          isr_any;
  logic [IW-1:0] isr_idx;
  logic          ack_ok;
  logic [N-1:0]  isr_set;
  logic [N-1:0]  eoi_clr;

  // fixed-priority search, index 0 wins
  always_comb begin
    cand     = irr & ~mask;
    cand_any = 1'b0;
    cand_idx = '0;
    isr_any  = 1'b0;
    isr_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        cand_any = 1'b1;
        cand_idx = IW'(i);
      end
      if (isr_q[i]) begin
        isr_any = 1'b1;
        isr_idx = IW'(i);
      end
    end
  end

  always_comb begin
    int_req = ready & cand_any & (~isr_any | (cand_idx < isr_idx));
    ack_ok  = ack & int_req;
    ack_clr = '0;
    isr_set = '0;
    eoi_clr = '0;
    if (ack_ok) begin
      ack_clr[cand_idx] = 1'b1;
      if (!auto_eoi) isr_set[cand_idx] = 1'b1;
    end
    if (eoi && isr_any) eoi_clr[isr_idx] = 1'b1;
    isr_nx = clr_all ? '0 : ((isr_q & ~eoi_clr) | isr_set);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      isr_q <= '0;
    end else begin
      isr_q <= isr_nx;
    end
  end

  assign grant_idx = cand_idx;

  // R6
  aeoi_no_service_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ack_ok && auto_eoi && !eoi && !clr_all |=> isr_q == $past(isr_q));

  // R9
  ack_service_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ack_ok && !auto_eoi && !eoi && !clr_all |=> isr_q[$past(cand_idx)]);

  // R10
  eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    eoi && !ack_ok && !clr_all && (isr_q != '0)
    |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

endmodule

// File: rtl/pic_cfg_unit.sv
module pic_cfg_unit #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          port_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          master_sel,
  input  logic [DW-1:0] irq_in,
  input  logic          int_ack,
  output logic          int_req,
  output logic [DW-1:0] int_vector,
  output logic          cfg_ready,
  output logic          cfg_level_mode,
  output logic          cfg_auto_eoi,
  output logic [DW-1:0] cfg_slave_mask,
  output logic [$clog2(DW)-1:0] cfg_slave_id
);

  localparam int unsigned N  = DW;
  localparam int unsigned IW = $clog2(DW);

  logic          rst_ns;
  logic          cmd_init;
  logic          cmd_eoi;
  logic          ready;
  logic [DW-1:0] vec_base;
  logic [DW-1:0] casc_word;
  logic          level_mode;
  logic          auto_eoi;
  logic [N-1:0]  mask;
  logic [N-1:0]  irr;
  logic [N-1:0]  ack_clr;
  logic [IW-1:0] grant_idx;
  logic          req;

  pic_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  pic_init_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .wr_en      (wr_en),
    .port_sel   (port_sel),
    .wdata      (wdata),
    .cmd_init   (cmd_init),
    .cmd_eoi    (cmd_eoi),
    .ready      (ready),
    .vec_base   (vec_base),
    .casc_word  (casc_word),
    .level_mode (level_mode),
    .auto_eoi   (auto_eoi),
    .mask       (mask)
  );

  pic_req_latch #(.N(N)) u_irr (
    .clk        (clk),
    .rst_ns     (rst_ns),
    .irq        (irq_in),
    .level_mode (level_mode),
    .clr_all    (cmd_init),
    .ack_clr    (ack_clr),
    .irr        (irr)
  );

  pic_prio_svc #(.N(N), .IW(IW)) u_prio (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .irr       (irr),
    .mask      (mask),
    .ready     (ready),
    .ack       (int_ack),
    .eoi       (cmd_eoi),
    .clr_all   (cmd_init),
    .auto_eoi  (auto_eoi),
    .int_req   (req),
    .grant_idx (grant_idx),
    .ack_clr   (ack_clr)
  );

  always_comb begin
    rdata          = (rd_en && port_sel) ? mask : '0;
    int_req        = req;
    int_vector     = req ? (vec_base + {{(DW-IW){1'b0}}, grant_idx}) : '0;
    cfg_ready      = ready;
    cfg_level_mode = level_mode;
    cfg_auto_eoi   = auto_eoi;
    cfg_slave_mask = master_sel ? casc_word : '0;
    cfg_slave_id   = master_sel ? '0 : casc_word[IW-1:0];
  end

  // R8
  grant_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    req |-> !mask[grant_idx] && irr[grant_idx]);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !$past(rst_ns) |-> !req && !ready);

endmodule

// File: tb/pic_cfg_unit_tb.sv
module pic_cfg_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       rd_en;
  logic       port_sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       master_sel;
  logic [7:0] irq_in;
  logic       int_ack;
  logic       int_req;
  logic [7:0] int_vector;
  logic       cfg_ready;
  logic       cfg_level_mode;
  logic       cfg_auto_eoi;
  logic [7:0] cfg_slave_mask;
  logic [2:0] cfg_slave_id;

  int checks;
  int errors;
  bit started;
  bit done;

  pic_cfg_unit dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .port_sel       (port_sel),
    .wdata          (wdata),
    .rdata          (rdata),
    .master_sel     (master_sel),
    .irq_in         (irq_in),
    .int_ack        (int_ack),
    .int_req        (int_req),
    .int_vector     (int_vector),
    .cfg_ready      (cfg_ready),
    .cfg_level_mode (cfg_level_mode),
    .cfg_auto_eoi   (cfg_auto_eoi),
    .cfg_slave_mask (cfg_slave_mask),
    .cfg_slave_id   (cfg_slave_id)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_st;          // 0 uninit, 1 base, 2 cascade, 3 mode, 4 ready
  int m_mask, m_isr, m_irr, m_prev, m_base, m_casc;
  bit m_need, m_single, m_level, m_aeoi;
  int m_rcnt;

  task automatic model_reset();
    m_st = 0; m_mask = 8'hFF; m_isr = 0; m_irr = 0; m_prev = 0;
    m_base = 0; m_casc = 0; m_need = 0; m_single = 0; m_level = 0; m_aeoi = 0;
  endtask

  function automatic int lowest(input int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit m_req();
    int c;
    c = m_irr & ~m_mask & 8'hFF;
    return (m_st == 4) && (c != 0) && (lowest(c) < lowest(m_isr));
  endfunction

  task automatic model_step();
    int c, ci, rise, eclr, sset;
    bit ack_ok, init, eoi;
    c      = m_irr & ~m_mask & 8'hFF;
    ci     = lowest(c);
    ack_ok = int_ack && m_req();
    init   = wr_en && !port_sel && wdata[4];
    eoi    = wr_en && !port_sel && !wdata[4] && !wdata[3] && wdata[7:5] == 3'b001 && m_st == 4;
    rise   = irq_in & ~m_prev & 8'hFF;
    if (init) begin
      m_st = 1; m_need = wdata[0]; m_single = wdata[1]; m_level = wdata[3];
      m_aeoi = 0; m_mask = 0; m_isr = 0; m_irr = 0; m_casc = 0;
    end else begin
      if (wr_en && port_sel) begin
        case (m_st)
          1: begin m_base = wdata; m_st = !m_single ? 2 : (m_need ? 3 : 4); end
          2: begin m_casc = wdata; m_st = m_need ? 3 : 4; end
          3: begin m_aeoi = wdata[1]; m_st = 4; end
          4: m_mask = wdata;
          default: ;
        endcase
      end
      eclr = (eoi && m_isr != 0) ? (1 << lowest(m_isr)) : 0;
      sset = (ack_ok && !m_aeoi) ? (1 << ci) : 0;
      if (m_level) m_irr = irq_in;
      else m_irr = ((m_irr & ~(ack_ok ? (1 << ci) : 0)) | rise) & 8'hFF;
      m_isr = ((m_isr & ~eclr) | sset) & 8'hFF;
    end
    m_prev = irq_in;
  endtask

  always @(posedge clk) begin
    started = 1'b1;
    if (!rst_n) begin
      model_reset();
      m_rcnt = 0;
    end else if (m_rcnt < 2) begin
      m_rcnt++;
    end else begin
      model_step();
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("R3 ready", cfg_ready, m_st == 4);
      check("R8 int_req", int_req, m_req());
      if (m_req())
        check("R4 vector", int_vector, (m_base + lowest(m_irr & ~m_mask & 8'hFF)) & 8'hFF);
      check("R7 rdata", rdata, (rd_en && port_sel) ? m_mask : 0);
      check("R5 slave mask", cfg_slave_mask, master_sel ? m_casc : 0);
      check("R5 slave id", cfg_slave_id, master_sel ? 0 : (m_casc & 7));
      check("R6 auto eoi", cfg_auto_eoi, m_aeoi);
      check("R11 level", cfg_level_mode, m_level);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    wr_en = 1'b1; port_sel = sel; wdata = d;
    tick();
    wr_en = 1'b0; port_sel = 1'b1; wdata = 8'h00;
  endtask

  task automatic ack();
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
  endtask

  task automatic expect_req(input string tag, input bit r, input int v);
    @(negedge clk);
    check(tag, int_req, r);
    if (r) check(tag, int_vector, v);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    checks = 0; errors = 0; started = 0; done = 0;
    model_reset(); m_rcnt = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b1; port_sel = 1'b1; wdata = 8'h00;
    master_sel = 1'b1; irq_in = 8'h00; int_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    @(negedge clk);
    check("R1 ready", cfg_ready, 0);
    check("R1 mask", rdata, 8'hFF);
    check("R1 int_req", int_req, 0);

    // R12: data write before initialization
    wr(1'b1, 8'h55);
    @(negedge clk);
    check("R12 mask kept", rdata, 8'hFF);

    // master: edge, cascade, mode word follows
    wr(1'b0, 8'h11);
    @(negedge clk);
    check("R2 mask cleared", rdata, 8'h00);
    check("R2 not ready", cfg_ready, 0);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h04);
    @(negedge clk);
    check("R3 waiting for mode word", cfg_ready, 0);
    wr(1'b1, 8'h01);
    @(negedge clk);
    check("R3 ready", cfg_ready, 1);
    check("R5 master mask", cfg_slave_mask, 8'h04);

    irq_in = 8'h28; tick();
    expect_req("R8 input 3 first", 1, 8'h23);
    ack();
    expect_req("R9 lower blocked by service", 0, 0);
    irq_in = 8'h2A; tick();
    expect_req("R8 higher preempts", 1, 8'h21);
    ack();
    expect_req("R9 nested in service", 0, 0);
    wr(1'b0, 8'h20);
    expect_req("R10 first retire", 0, 0);
    wr(1'b0, 8'h20);
    expect_req("R10 second retire", 1, 8'h25);
    ack();
    wr(1'b0, 8'h20);
    repeat (2) tick();
    expect_req("R11 held high no rerequest", 0, 0);

    // R7: mask all, then read-modify-write
    wr(1'b1, 8'hFF);
    irq_in = 8'h00; tick();
    irq_in = 8'h81; tick();
    expect_req("R7 all masked", 0, 0);
    wr(1'b1, 8'h7F);
    expect_req("R7 unmasked input 7", 1, 8'h27);
    check("R7 read back", rdata, 8'h7F);
    rd_en = 1'b0; #1;
    check("R7 no read strobe", rdata, 8'h00);
    rd_en = 1'b1;
    ack();
    wr(1'b0, 8'h20);

    // single controller, auto EOI
    irq_in = 8'h00;
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h70);
    wr(1'b1, 8'h03);
    @(negedge clk);
    check("R3 single skips cascade", cfg_ready, 1);
    check("R5 no cascade word", cfg_slave_mask, 0);
    check("R6 auto eoi set", cfg_auto_eoi, 1);
    irq_in = 8'h06; tick();
    expect_req("R6 first", 1, 8'h71);
    ack();
    expect_req("R6 next without eoi", 1, 8'h72);
    ack();
    expect_req("R6 drained", 0, 0);

    // slave, level mode
    irq_in = 8'h00; master_sel = 1'b0;
    wr(1'b0, 8'h19);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h01);
    @(negedge clk);
    check("R5 slave id", cfg_slave_id, 2);
    check("R11 level set", cfg_level_mode, 1);
    irq_in = 8'h04; tick();
    expect_req("R11 level request", 1, 8'h0A);
    irq_in = 8'h00; tick();
    expect_req("R11 level drop", 0, 0);

    // master, no mode word, vector wrap
    master_sel = 1'b1;
    wr(1'b0, 8'h10);
    wr(1'b1, 8'hFE);
    @(negedge clk);
    check("R3 waits for cascade", cfg_ready, 0);
    wr(1'b1, 8'h01);
    @(negedge clk);
    check("R3 ready without mode word", cfg_ready, 1);
    check("R5 master mask", cfg_slave_mask, 8'h01);
    irq_in = 8'h04; tick();
    expect_req("R4 vector wraps", 1, 8'h00);

    repeat (3) tick();
    done = 1'b1;
    report();
    $finish;
  end

endmodule